// File: doc/BRIEF.md
# Serial Configuration Loader

This block boots a programmable logic device from a byte-wide parallel memory. The memory holds two configuration images, one in its lower half and one in its upper half. The active image is chosen by a board jumper at reset, and a bus command can later override that choice. When the device's program line is pulled low and then released, the loader waits for the device to release its init line. It then reads the active half from offset zero, one byte at a time, and shifts each byte out most significant bit first on a serial data line. A configuration clock goes with the data.

The serial data changes only while the configuration clock is low, so it is stable at every rising edge. Loading ends when the device raises done, or when the full image byte count has been sent. If the count is reached without done, an error flag is raised. Pulling the program line low again at any time aborts the transfer and prepares a new load from the half that is selected at that moment.

Top module: `cfg_loader`

## Requirements
- R1: After reset the block is idle: busy, mem_oe, cfg_cclk and load_error are all 0.
- R2: A load starts only after prog_n has been low and then high, and after that init_n is high. Before this, no rising edge appears on cfg_cclk and mem_oe stays 0.
- R3: Byte k of a load is read from mem_addr = {sel, k}. The top bit is the half select and the low OFS_W bits are the offset, starting at 0 and increasing by one per byte. The half select is taken at the release of prog_n.
- R4: Each byte becomes DATA_W serial bits, most significant first. cfg_dout is sampled at the rising edge of cfg_cclk and changes only while cfg_cclk is low.
- R5: At reset the half select takes the value of jumper_sel. A one-cycle pulse on sel_set_valid loads sel_set_value as the select for the next load. A pulse that arrives during a load does not change the load in progress.
- R6: While cfg_done is high during a load, the transfer stops within one cycle. After that there are no further rising edges on cfg_cclk, busy falls and load_error stays 0.
- R7: If all IMAGE_BYTES bytes are sent without cfg_done, load_error rises and busy falls. Exactly IMAGE_BYTES bytes are clocked out.
- R8: prog_n low forces busy, cfg_cclk, mem_oe and load_error to 0 on the next clock.
- R9: mem_oe is high only while busy, for one cycle per byte fetch, and the memory data is captured in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| jumper_sel | input | 1 | Half select applied at reset |
| sel_set_valid | input | 1 | Bus command strobe that overrides the half select |
| sel_set_value | input | 1 | Half select carried by the bus command |
| prog_n | input | 1 | Device program line, low holds the device in reset |
| init_n | input | 1 | Device init line, high when the device is ready for data |
| cfg_done | input | 1 | Device reports configuration complete |
| mem_data | input | DATA_W | Memory read data, valid while mem_oe is high |
| mem_addr | output | OFS_W+1 | Memory byte address {half, offset} |
| mem_oe | output | 1 | Memory output enable |
| cfg_dout | output | 1 | Serial configuration data |
| cfg_cclk | output | 1 | Configuration clock |
| busy | output | 1 | Load in progress |
| load_error | output | 1 | Image count reached without done |

## Verification
The assertions assume that the memory answers combinationally: mem_data reflects mem_addr in the same cycle that mem_oe is high. They also assume that prog_n, init_n and cfg_done are synchronous to clk. The bench models the memory as a pure function of the address, gated by mem_oe. It changes every control input half a cycle away from the rising edge. It raises cfg_done only once a whole byte has been clocked out, and it pulses the select command for exactly one cycle.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_WAIT_INIT,
    ST_FETCH,
    ST_SHIFT,
    ST_DONE,
    ST_FAIL
  } ldr_state_t;
endpackage

// File: rtl/cfg_sector_sel.sv
module cfg_sector_sel (
  input  logic clk,
  input  logic rst,
  input  logic jumper_sel,
  input  logic set_valid,
  input  logic set_value,
  output logic sel
);
  always_ff @(posedge clk) begin
    if (rst)            sel <= jumper_sel;
    else if (set_valid) sel <= set_value;
  end
endmodule

// File: rtl/cfg_addr_gen.sv
module cfg_addr_gen #(
  parameter int OFS_W       = 18,
  parameter int IMAGE_BYTES = 166980
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clear,
  input  logic           sel_in,
  input  logic           step,
  output logic [OFS_W:0] addr,
  output logic           at_last
);
  localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(IMAGE_BYTES - 1);

  logic             half_q;
  logic [OFS_W-1:0] ofs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= 1'b0;
      ofs_q  <= '0;
    end else if (clear) begin
      half_q <= sel_in;
      ofs_q  <= '0;
    end else if (step) begin
      ofs_q  <= ofs_q + 1'b1;
    end
  end

  assign addr    = {half_q, ofs_q};
  assign at_last = (ofs_q == LAST_OFS);
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  logic              tick,
  output logic              dout,
  output logic              cclk,
  output logic              last_bit
);
  localparam int BW = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [BW-1:0] LAST_IDX = BW'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q;
  logic [BW-1:0]     idx_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sh_q  <= '0;
      idx_q <= '0;
      dout  <= 1'b0;
      cclk  <= 1'b0;
    end else if (load) begin
      sh_q  <= data;
      idx_q <= '0;
      dout  <= data[DATA_W-1];
      cclk  <= 1'b0;
    end else if (tick) begin
      if (!cclk) begin
        cclk <= 1'b1;
      end else begin
        cclk <= 1'b0;
        if (idx_q != LAST_IDX) begin
          sh_q  <= sh_q << 1;
          dout  <= sh_q[DATA_W-2];
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign last_bit = cclk && (idx_q == LAST_IDX);
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OFS_W       = 18,
  parameter int IMAGE_BYTES = 166980
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              jumper_sel,
  input  logic              sel_set_valid,
  input  logic              sel_set_value,
  input  logic              prog_n,
  input  logic              init_n,
  input  logic              cfg_done,
  input  logic [DATA_W-1:0] mem_data,
  output logic [OFS_W:0]    mem_addr,
  output logic              mem_oe,
  output logic              cfg_dout,
  output logic              cfg_cclk,
  output logic              busy,
  output logic              load_error
);
  ldr_state_t state;
  logic sel, at_last, last_bit;
  logic stop_now, sh_clear, sh_load, sh_tick, a_clear, a_step;

  cfg_sector_sel u_sel (
    .clk(clk), .rst(rst), .jumper_sel(jumper_sel),
    .set_valid(sel_set_valid), .set_value(sel_set_value), .sel(sel)
  );

  cfg_addr_gen #(.OFS_W(OFS_W), .IMAGE_BYTES(IMAGE_BYTES)) u_addr (
    .clk(clk), .rst(rst), .clear(a_clear), .sel_in(sel),
    .step(a_step), .addr(mem_addr), .at_last(at_last)
  );

  cfg_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .clear(sh_clear), .load(sh_load), .data(mem_data),
    .tick(sh_tick), .dout(cfg_dout), .cclk(cfg_cclk), .last_bit(last_bit)
  );

  always_comb begin
    stop_now = ((state == ST_FETCH) && cfg_done) ||
               ((state == ST_SHIFT) && (cfg_done || (last_bit && at_last)));
    sh_clear = !prog_n || stop_now || (state == ST_HOLD);
    sh_load  = prog_n && (state == ST_FETCH) && !cfg_done;
    sh_tick  = prog_n && (state == ST_SHIFT);
    a_clear  = (state == ST_HOLD);
    a_step   = prog_n && (state == ST_SHIFT) && !cfg_done && last_bit && !at_last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      busy       <= 1'b0;
      mem_oe     <= 1'b0;
      load_error <= 1'b0;
    end else if (!prog_n) begin
      state      <= ST_HOLD;
      busy       <= 1'b0;
      mem_oe     <= 1'b0;
      load_error <= 1'b0;
    end else begin
      case (state)
        ST_HOLD: state <= ST_WAIT_INIT;
        ST_WAIT_INIT: begin
          if (init_n) begin
            state  <= ST_FETCH;
            busy   <= 1'b1;
            mem_oe <= 1'b1;
          end
        end
        ST_FETCH: begin
          mem_oe <= 1'b0;
          if (cfg_done) begin
            state <= ST_DONE;
            busy  <= 1'b0;
          end else begin
            state <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (cfg_done) begin
            state <= ST_DONE;
            busy  <= 1'b0;
          end else if (last_bit) begin
            if (at_last) begin
              state      <= ST_FAIL;
              busy       <= 1'b0;
              load_error <= 1'b1;
            end else begin
              state  <= ST_FETCH;
              mem_oe <= 1'b1;
            end
          end
        end
        default: state <= state;
      endcase
    end
  end
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
  parameter int OFS_W = 18
) (
  input logic           clk,
  input logic           rst,
  input logic           prog_n,
  input logic [OFS_W:0] mem_addr,
  input logic           mem_oe,
  input logic           cfg_dout,
  input logic           cfg_cclk,
  input logic           busy,
  input logic           load_error
);
  p_dout_hold_r4: assert property (@(posedge clk) disable iff (rst)
    cfg_cclk |-> $stable(cfg_dout));

  p_oe_busy_r9: assert property (@(posedge clk) disable iff (rst)
    mem_oe |-> busy);

  p_abort_r8: assert property (@(posedge clk) disable iff (rst)
    !prog_n |=> (!busy && !cfg_cclk && !mem_oe && !load_error));

  p_err_idle_r7: assert property (@(posedge clk) disable iff (rst)
    load_error |-> (!busy && !cfg_cclk));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!cfg_cclk && !mem_oe));

  p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && (mem_addr != $past(mem_addr))) |->
      (mem_addr == $past(mem_addr) + {{OFS_W{1'b0}}, 1'b1}));
endmodule

bind cfg_loader cfg_loader_chk #(.OFS_W(OFS_W)) i_chk (
  .clk(clk), .rst(rst), .prog_n(prog_n), .mem_addr(mem_addr),
  .mem_oe(mem_oe), .cfg_dout(cfg_dout), .cfg_cclk(cfg_cclk),
  .busy(busy), .load_error(load_error)
);

// File: tb/test_cfg_loader.sv
module test_cfg_loader;
  localparam int DW  = 8;
  localparam int OW  = 18;
  localparam int IMG = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic jumper_sel = 1'b0, sel_set_valid = 1'b0, sel_set_value = 1'b0;
  logic prog_n = 1'b0, init_n = 1'b0, cfg_done = 1'b0;
  logic [DW-1:0] mem_data;
  logic [OW:0]   mem_addr;
  logic mem_oe, cfg_dout, cfg_cclk, busy, load_error;

  int checks = 0, fails = 0, cyc = 0;
  int rises = 0, nbytes = 0, nbit = 0, nlog = 0, glitches = 0;
  logic [7:0]  cap  [64];
  logic [OW:0] alog [64];
  logic [7:0]  cur = '0;
  logic prev_cclk = 1'b0, prev_dout = 1'b0;

  always #4 clk = ~clk;

  cfg_loader #(.DATA_W(DW), .OFS_W(OW), .IMAGE_BYTES(IMG)) i_cfg_loader (
    .clk(clk), .rst(rst), .jumper_sel(jumper_sel), .sel_set_valid(sel_set_valid),
    .sel_set_value(sel_set_value), .prog_n(prog_n), .init_n(init_n),
    .cfg_done(cfg_done), .mem_data(mem_data), .mem_addr(mem_addr),
    .mem_oe(mem_oe), .cfg_dout(cfg_dout), .cfg_cclk(cfg_cclk),
    .busy(busy), .load_error(load_error)
  );

  function automatic logic [7:0] mem_byte(input logic [OW:0] a);
    return (a[7:0] * 8'd29) ^ {a[OW], a[6:0]} ^ 8'h5A;
  endfunction

  assign mem_data = mem_oe ? mem_byte(mem_addr) : 8'h00;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cfg_cclk && !prev_cclk) begin
      rises++;
      cur = {cur[6:0], cfg_dout};
      nbit++;
      if (nbit == 8) begin
        if (nbytes < 64) cap[nbytes] = cur;
        nbytes++;
        nbit = 0;
      end
    end
    if (cfg_cclk && prev_cclk && (cfg_dout != prev_dout)) glitches++;
    if (mem_oe) begin
      if (nlog < 64) alog[nlog] = mem_addr;
      nlog++;
    end
    prev_cclk = cfg_cclk;
    prev_dout = cfg_dout;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", fails, checks);
      $finish;
    end
  end

  task automatic clear_logs();
    rises = 0; nbytes = 0; nbit = 0; nlog = 0; glitches = 0;
  endtask

  task automatic set_sel(input logic v);
    @(negedge clk); sel_set_valid = 1'b1; sel_set_value = v;
    @(negedge clk); sel_set_valid = 1'b0;
  endtask

  task automatic start_load(input int init_delay);
    @(negedge clk); prog_n = 1'b0; init_n = 1'b0; cfg_done = 1'b0;
    repeat (3) @(negedge clk);
    clear_logs();
    prog_n = 1'b1;
    repeat (init_delay) @(negedge clk);
    if (init_delay > 0)
      chk(rises == 0 && nlog == 0, "R2 no activity before init", rises + nlog, 0);
    init_n = 1'b1;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic check_stream(input logic sel, input int cnt);
    for (int i = 0; i < cnt && i < 64; i++) begin
      chk(cap[i] == mem_byte({sel, OW'(i)}), "R4 serial byte MSB first",
          int'(cap[i]), int'(mem_byte({sel, OW'(i)})));
      chk(alog[i] == {sel, OW'(i)}, "R3 fetch address", int'(alog[i]), int'({sel, OW'(i)}));
    end
    chk(glitches == 0, "R4 data stable while clock high", glitches, 0);
  endtask

  initial begin
    process::self().srandom(32'd1234);
    repeat (5) @(negedge clk);
    chk(!busy && !mem_oe && !cfg_cclk && !load_error, "R1 reset state",
        {busy, mem_oe, cfg_cclk, load_error}, 0);
    rst = 1'b0;

    // Full image without done, lower half from the jumper
    start_load(10);
    wait_idle();
    chk(nbytes == IMG, "R7 byte count", nbytes, IMG);
    chk(rises == IMG * 8, "R4 clock edges per image", rises, IMG * 8);
    chk(load_error == 1'b1, "R7 error flag", load_error, 1);
    chk(nlog == IMG, "R9 one enable per byte", nlog, IMG);
    check_stream(1'b0, IMG);

    // Random loads with done part way through
    for (int it = 0; it < 4; it++) begin
      logic s;
      int k;
      s = 1'($urandom_range(0, 1));
      k = int'($urandom_range(2, IMG - 2));
      set_sel(s);
      start_load(int'($urandom_range(0, 5)));
      while (nbytes < k) @(negedge clk);
      cfg_done = 1'b1;
      wait_idle();
      repeat (3) @(negedge clk);
      begin
        int r0;
        r0 = rises;
        repeat (20) @(negedge clk);
        chk(rises == r0, "R6 no clock after done", rises, r0);
      end
      chk(nbytes == k, "R6 bytes before done", nbytes, k);
      chk(load_error == 1'b0 && busy == 1'b0, "R6 clean stop", {load_error, busy}, 0);
      check_stream(s, k);
      cfg_done = 1'b0;
    end

    // Override during a load leaves that load untouched
    set_sel(1'b0);
    start_load(0);
    while (nbytes < 3) @(negedge clk);
    set_sel(1'b1);
    wait_idle();
    chk(nbytes == IMG, "R5 load kept running", nbytes, IMG);
    check_stream(1'b0, IMG);
    start_load(2);
    wait_idle();
    chk(alog[0] == {1'b1, OW'(0)}, "R5 next load uses new select",
        int'(alog[0]), int'({1'b1, OW'(0)}));
    check_stream(1'b1, IMG);

    // Abort by program line
    start_load(0);
    while (nbytes < 2) @(negedge clk);
    prog_n = 1'b0; init_n = 1'b0;
    @(negedge clk);
    chk(!busy && !cfg_cclk && !mem_oe && !load_error, "R8 abort",
        {busy, cfg_cclk, mem_oe, load_error}, 0);
    set_sel(1'b0);
    start_load(1);
    while (nbytes < 3) @(negedge clk);
    cfg_done = 1'b1;
    wait_idle();
    cfg_done = 1'b0;
    chk(nbytes == 3, "R8 restart from base", nbytes, 3);
    check_stream(1'b0, 3);

    // Reset returns select to the jumper
    jumper_sel = 1'b1;
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !mem_oe && !cfg_cclk && !load_error, "R1 idle after reset",
        {busy, mem_oe, cfg_cclk, load_error}, 0);
    rst = 1'b0;
    start_load(0);
    while (nbytes < 2) @(negedge clk);
    cfg_done = 1'b1;
    wait_idle();
    cfg_done = 1'b0;
    chk(alog[0][OW] == 1'b1, "R5 jumper select at reset", int'(alog[0][OW]), 1);
    check_stream(1'b1, 2);

    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end
endmodule